// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port memory of 9-bit words. Each of the two ports, left and right, has its own clock, chip enables, read/write select, output enable, address and data buses. Each port's address also passes through its own address register, which doubles as a burst counter. An active-low address strobe loads the counter from the external bus. An active-low count enable advances it by one. An active-low counter reset clears it to zero. Because the counter is built into the port, a host can stream through consecutive words after giving only the first address.

Each port has a mode input that selects its read latency. In flow-through mode the word appears during the cycle after the edge that registers the address. In pipelined mode the word passes through one more register and appears one cycle later. A data-valid output stands in for a tri-state data bus. It is high only on cycles that carry read data the host should take.

The depth is set by `ADDR_W`: 13 gives 8K words and 14 gives 16K words. The default of 10 keeps short builds small. Both ports may reach any word at the same time. Only the case where both ports write the same word on one edge is resolved, in favour of the left port. That resolution assumes the two clocks share edges.

Top module: `dual_port_burst_ram`

## Requirements
- R1: Every word holds 9 bits, and a word written through one port is read back unchanged through the other port.
- R2: A port is selected only when its chip enable 0 is low and its chip enable 1 is high. A deselected port writes nothing and keeps its data-valid output low.
- R3: With counter reset high and the address strobe low, the port's address register takes the external address on that edge.
- R4: With the strobe high and count enable low, the address register increases by one per edge. With count enable also high, it holds its value.
- R5: Counter reset low clears the address register to 0, taking priority over strobe and count. It also clears the port's pending read-valid stages.
- R6: Counting past the top address (all ones) wraps the address register to 0.
- R7: With the mode input low (flow-through), a selected read registered on edge k gives data and data-valid high in the cycle after edge k.
- R8: With the mode input high (pipelined), the same read gives data and data-valid high only after edge k+1. After edge k, data-valid still shows the previous cycle's read state.
- R9: Data-valid is low for the cycle that follows a write operation, or an edge at which output enable was high.
- R10: When both ports write the same address on the same edge, the left port's word is stored.
- R11: A read registered on the same edge as the other port's write to that address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkL | input | 1 | Left port clock |
| ce0NL | input | 1 | Left chip enable 0, active low |
| ce1L | input | 1 | Left chip enable 1, active high |
| rdWrL | input | 1 | Left read (1) / write (0) |
| oeNL | input | 1 | Left output enable, active low |
| adsNL | input | 1 | Left address strobe, active low |
| cntEnNL | input | 1 | Left count enable, active low |
| cntRstNL | input | 1 | Left counter reset, active low |
| pipeModeL | input | 1 | Left read mode: 0 flow-through, 1 pipelined |
| addrL | input | ADDR_W | Left external address |
| dinL | input | DATA_W | Left write data |
| doutL | output | DATA_W | Left read data |
| doutValidL | output | 1 | Left read data valid |
| clkR | input | 1 | Right port clock |
| ce0NR | input | 1 | Right chip enable 0, active low |
| ce1R | input | 1 | Right chip enable 1, active high |
| rdWrR | input | 1 | Right read (1) / write (0) |
| oeNR | input | 1 | Right output enable, active low |
| adsNR | input | 1 | Right address strobe, active low |
| cntEnNR | input | 1 | Right count enable, active low |
| cntRstNR | input | 1 | Right counter reset, active low |
| pipeModeR | input | 1 | Right read mode: 0 flow-through, 1 pipelined |
| addrR | input | ADDR_W | Right external address |
| dinR | input | DATA_W | Right write data |
| doutR | output | DATA_W | Right read data |
| doutValidR | output | 1 | Right read data valid |

## Verification
If a burst counter takes a wrong step, the next read through that port returns the word from a neighbouring address. In flow-through mode this shows in the cycle after the bad edge, and in pipelined mode one cycle later. So the burst tests place different words at adjacent addresses, at the top address and at address 0. A bad live-value tag or a lost collision shows as the other port's word at the conflicting address. It appears on the first read of that address after the write. A valid stage that is not cleared shows as data-valid high on a write, deselect or counter-reset cycle.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Per-port strobes handed from the port control to the datapath.
  typedef struct packed {
    logic wrEn;     // write this edge at the operation address
    logic rdStage;  // a read was registered on the last edge
  } portStrobe_t;

  function automatic logic portSelected(input logic ce0N, input logic ce1);
    return !ce0N && ce1;
  endfunction

endpackage

// File: rtl/dpPortCtrl.sv
module dpPortCtrl
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              ce0N,
  input  logic              ce1,
  input  logic              rdWr,
  input  logic              oeN,
  input  logic              adsN,
  input  logic              cntEnN,
  input  logic              cntRstN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] opAddr,
  output logic [ADDR_W-1:0] addrReg,
  output portStrobe_t       strb
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic sel;
  logic rdStageQ;

  assign sel = portSelected(ce0N, ce1);

  // Counter priority: reset, then strobe load, then count, else hold.
  always_comb begin
    if (!cntRstN)      opAddr = '0;
    else if (!adsN)    opAddr = addrIn;
    else if (!cntEnN)  opAddr = addrReg + ONE;
    else               opAddr = addrReg;
  end

  always_ff @(posedge clk) begin
    addrReg <= opAddr;
    if (!cntRstN) rdStageQ <= 1'b0;
    else          rdStageQ <= sel && rdWr && !oeN;
  end

  assign strb.wrEn    = sel && !rdWr;
  assign strb.rdStage = rdStageQ;

  // R3
  load_addr_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (cntRstN && !adsN) |=> (addrReg == $past(addrIn)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (cntRstN && adsN && !cntEnN) |=> (addrReg == $past(addrReg) + ONE));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (cntRstN && adsN && cntEnN) |=> $stable(addrReg));

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    !sel |=> !strb.rdStage);

  // R9
  write_no_valid_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (!rdWr || oeN) |=> !strb.rdStage);

endmodule

// File: rtl/dpArray.sv
module dpArray #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              chkRstN,
  input  logic              clkL,
  input  logic              wrL,
  input  logic [ADDR_W-1:0] waL,
  input  logic [DATA_W-1:0] wdL,
  input  logic [ADDR_W-1:0] raL,
  output logic [DATA_W-1:0] rdL,
  input  logic              clkR,
  input  logic              wrR,
  input  logic [ADDR_W-1:0] waR,
  input  logic [DATA_W-1:0] wdR,
  input  logic [ADDR_W-1:0] raR,
  output logic [DATA_W-1:0] rdR
);

  localparam int DEPTH = 1 << ADDR_W;

  // One bank per writing port plus a live-value tag pair per word:
  // tags unequal -> left bank holds the latest word, equal -> right bank.
  logic [DATA_W-1:0] memL [DEPTH];
  logic [DATA_W-1:0] memR [DEPTH];
  logic              tagL [DEPTH] = '{default: 1'b0};
  logic              tagR [DEPTH] = '{default: 1'b0};

  logic wrREff;

  // Same-edge collision: the left port wins, the right write is dropped.
  assign wrREff = wrR && !(wrL && (waL == waR));

  always_ff @(posedge clkL) begin
    if (wrL) begin
      memL[waL] <= wdL;
      tagL[waL] <= !tagR[waL];
    end
  end

  always_ff @(posedge clkR) begin
    if (wrREff) begin
      memR[waR] <= wdR;
      tagR[waR] <= tagL[waR];
    end
  end

  assign rdL = (tagL[raL] != tagR[raL]) ? memL[raL] : memR[raL];
  assign rdR = (tagL[raR] != tagR[raR]) ? memL[raR] : memR[raR];

  // R10
  left_owns_word_chk: assert property (@(posedge clkL) disable iff (!chkRstN)
    wrL |=> (tagL[$past(waL)] != tagR[$past(waL)]));

  // R10
  right_dropped_chk: assert property (@(posedge clkL) disable iff (!chkRstN)
    (wrL && wrR && (waL == waR)) |=> (tagR[$past(waR)] == $past(tagR[waR])));

endmodule

// File: rtl/dpReadOut.sv
module dpReadOut
  import dpram_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              cntRstN,
  input  logic              pipeMode,
  input  portStrobe_t       strb,
  input  logic [DATA_W-1:0] arrData,
  output logic [DATA_W-1:0] dout,
  output logic              doutValid
);

  logic [DATA_W-1:0] pipeData;
  logic              pipeVal;

  always_ff @(posedge clk) begin
    pipeData <= arrData;
    if (!cntRstN) pipeVal <= 1'b0;
    else          pipeVal <= strb.rdStage;
  end

  assign dout      = pipeMode ? pipeData : arrData;
  assign doutValid = pipeMode ? pipeVal  : strb.rdStage;

  // R8
  pipe_lag_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (pipeMode && strb.rdStage) |=> (!pipeMode || doutValid));

  // R8
  pipe_idle_chk: assert property (@(posedge clk) disable iff (!cntRstN)
    (pipeMode && !strb.rdStage) |=> (!pipeMode || !doutValid));

endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clkL,
  input  logic              ce0NL,
  input  logic              ce1L,
  input  logic              rdWrL,
  input  logic              oeNL,
  input  logic              adsNL,
  input  logic              cntEnNL,
  input  logic              cntRstNL,
  input  logic              pipeModeL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic [DATA_W-1:0] dinL,
  output logic [DATA_W-1:0] doutL,
  output logic              doutValidL,
  input  logic              clkR,
  input  logic              ce0NR,
  input  logic              ce1R,
  input  logic              rdWrR,
  input  logic              oeNR,
  input  logic              adsNR,
  input  logic              cntEnNR,
  input  logic              cntRstNR,
  input  logic              pipeModeR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic [DATA_W-1:0] dinR,
  output logic [DATA_W-1:0] doutR,
  output logic              doutValidR
);

  portStrobe_t       strbL, strbR;
  logic [ADDR_W-1:0] opAddrL, opAddrR, regAddrL, regAddrR;
  logic [DATA_W-1:0] arrL, arrR;

  dpPortCtrl #(.ADDR_W(ADDR_W)) uCtrlL (
    .clk(clkL), .ce0N(ce0NL), .ce1(ce1L), .rdWr(rdWrL), .oeN(oeNL),
    .adsN(adsNL), .cntEnN(cntEnNL), .cntRstN(cntRstNL), .addrIn(addrL),
    .opAddr(opAddrL), .addrReg(regAddrL), .strb(strbL)
  );

  dpPortCtrl #(.ADDR_W(ADDR_W)) uCtrlR (
    .clk(clkR), .ce0N(ce0NR), .ce1(ce1R), .rdWr(rdWrR), .oeN(oeNR),
    .adsN(adsNR), .cntEnN(cntEnNR), .cntRstN(cntRstNR), .addrIn(addrR),
    .opAddr(opAddrR), .addrReg(regAddrR), .strb(strbR)
  );

  dpArray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uArray (
    .chkRstN(cntRstNL),
    .clkL(clkL), .wrL(strbL.wrEn), .waL(opAddrL), .wdL(dinL),
    .raL(regAddrL), .rdL(arrL),
    .clkR(clkR), .wrR(strbR.wrEn), .waR(opAddrR), .wdR(dinR),
    .raR(regAddrR), .rdR(arrR)
  );

  dpReadOut #(.DATA_W(DATA_W)) uOutL (
    .clk(clkL), .cntRstN(cntRstNL), .pipeMode(pipeModeL), .strb(strbL),
    .arrData(arrL), .dout(doutL), .doutValid(doutValidL)
  );

  dpReadOut #(.DATA_W(DATA_W)) uOutR (
    .clk(clkR), .cntRstN(cntRstNR), .pipeMode(pipeModeR), .strb(strbR),
    .arrData(arrR), .dout(doutR), .doutValid(doutValidR)
  );

endmodule

// File: tb/sim_dual_port_burst_ram.sv
`timescale 1ns/1ps
module sim_dual_port_burst_ram;

  localparam int AW = 10;
  localparam int DW = 9;
  localparam logic [AW-1:0] TOP = '1;

  typedef struct packed {
    logic          adsN;
    logic          cntEnN;
    logic          rdWr;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          expV;
    logic [DW-1:0] expD;
  } vecT;

  // Left port, flow-through: load/count writes, then load/count/hold reads.
  localparam vecT TBL [8] = '{
    '{1'b0, 1'b1, 1'b0, 10'h010, 9'h1A5, 1'b0, 9'h000},
    '{1'b1, 1'b0, 1'b0, 10'h000, 9'h0F3, 1'b0, 9'h000},
    '{1'b1, 1'b0, 1'b0, 10'h000, 9'h100, 1'b0, 9'h000},
    '{1'b0, 1'b1, 1'b1, 10'h010, 9'h000, 1'b1, 9'h1A5},
    '{1'b1, 1'b0, 1'b1, 10'h000, 9'h000, 1'b1, 9'h0F3},
    '{1'b1, 1'b1, 1'b1, 10'h3AA, 9'h000, 1'b1, 9'h0F3},
    '{1'b1, 1'b0, 1'b1, 10'h000, 9'h000, 1'b1, 9'h100},
    '{1'b0, 1'b1, 1'b0, 10'h011, 9'h0F3, 1'b0, 9'h000}
  };

  logic clk = 1'b0;
  always #2.5 clk = !clk;

  logic ce0NL, ce1L, rdWrL, oeNL, adsNL, cntEnNL, cntRstNL, pipeModeL;
  logic ce0NR, ce1R, rdWrR, oeNR, adsNR, cntEnNR, cntRstNR, pipeModeR;
  logic [AW-1:0] addrL, addrR;
  logic [DW-1:0] dinL, dinR, doutL, doutR;
  logic doutValidL, doutValidR;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  dual_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clkL(clk), .ce0NL(ce0NL), .ce1L(ce1L), .rdWrL(rdWrL), .oeNL(oeNL),
    .adsNL(adsNL), .cntEnNL(cntEnNL), .cntRstNL(cntRstNL),
    .pipeModeL(pipeModeL), .addrL(addrL), .dinL(dinL), .doutL(doutL),
    .doutValidL(doutValidL),
    .clkR(clk), .ce0NR(ce0NR), .ce1R(ce1R), .rdWrR(rdWrR), .oeNR(oeNR),
    .adsNR(adsNR), .cntEnNR(cntEnNR), .cntRstNR(cntRstNR),
    .pipeModeR(pipeModeR), .addrR(addrR), .dinR(dinR), .doutR(doutR),
    .doutValidR(doutValidR)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Port setup helpers: selected, output enabled, counter running freely.
  task automatic opL(input logic ads, input logic cen, input logic rw,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0NL = 1'b0; ce1L = 1'b1; oeNL = 1'b0; cntRstNL = 1'b1;
    adsNL = ads; cntEnNL = cen; rdWrL = rw; addrL = a; dinL = d;
  endtask

  task automatic opR(input logic ads, input logic cen, input logic rw,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0NR = 1'b0; ce1R = 1'b1; oeNR = 1'b0; cntRstNR = 1'b1;
    adsNR = ads; cntEnNR = cen; rdWrR = rw; addrR = a; dinR = d;
  endtask

  task automatic idleR();
    ce0NR = 1'b1; ce1R = 1'b0; rdWrR = 1'b1; adsNR = 1'b1; cntEnNR = 1'b1;
  endtask

  task automatic idleL();
    ce0NL = 1'b1; ce1L = 1'b0; rdWrL = 1'b1; adsNL = 1'b1; cntEnNL = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    pipeModeL = 1'b0; pipeModeR = 1'b0;
    idleL(); idleR();
    oeNL = 1'b0; oeNR = 1'b0; addrL = '0; addrR = '0; dinL = '0; dinR = '0;
    cntRstNL = 1'b0; cntRstNR = 1'b0;
    tick(); tick();
    // R5: counter reset leaves no read pending on either port
    chk("R5 reset valid L", {15'd0, doutValidL}, 16'd0);
    chk("R5 reset valid R", {15'd0, doutValidR}, 16'd0);
    cntRstNL = 1'b1; cntRstNR = 1'b1;

    // R3 R4 R7 R9: table walk on the left port, flow-through
    foreach (TBL[i]) begin
      opL(TBL[i].adsN, TBL[i].cntEnN, TBL[i].rdWr, TBL[i].addr, TBL[i].din);
      tick();
      chk("R7/R9 table valid", {15'd0, doutValidL}, {15'd0, TBL[i].expV});
      if (TBL[i].expV)
        chk("R3/R4 table data", {7'd0, doutL}, {7'd0, TBL[i].expD});
    end
    idleL(); tick();

    // R1: right port reads a word the left port wrote
    opR(1'b0, 1'b1, 1'b1, 10'h011, 9'h000);
    tick();
    chk("R1 cross-port data", {6'd0, doutValidR, doutR}, {6'd0, 1'b1, 9'h0F3});
    idleR();

    // R9: output enable high keeps valid low
    opL(1'b0, 1'b1, 1'b1, 10'h010, 9'h000);
    oeNL = 1'b1;
    tick();
    chk("R9 oe high", {15'd0, doutValidL}, 16'd0);

    // R2: deselected write is ignored, valid stays low
    opL(1'b0, 1'b1, 1'b0, 10'h010, 9'h1FF);
    ce0NL = 1'b1;
    tick();
    chk("R2 ce0 high valid", {15'd0, doutValidL}, 16'd0);
    opL(1'b0, 1'b1, 1'b1, 10'h010, 9'h000);
    ce1L = 1'b0;
    tick();
    chk("R2 ce1 low valid", {15'd0, doutValidL}, 16'd0);
    opL(1'b0, 1'b1, 1'b1, 10'h010, 9'h000);
    tick();
    chk("R2 word kept", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h1A5});
    idleL(); tick();

    // R8: pipelined read on the right port appears one edge later
    pipeModeR = 1'b1;
    idleR(); tick();
    opR(1'b0, 1'b1, 1'b1, 10'h012, 9'h000);
    tick();
    chk("R8 pipe first edge", {15'd0, doutValidR}, 16'd0);
    opR(1'b1, 1'b1, 1'b1, 10'h000, 9'h000);
    tick();
    chk("R8 pipe second edge", {6'd0, doutValidR, doutR}, {6'd0, 1'b1, 9'h100});
    idleR(); tick(); tick();
    pipeModeR = 1'b0;

    // R10: same-edge writes to one word, left port wins
    opL(1'b0, 1'b1, 1'b0, 10'h020, 9'h111);
    opR(1'b0, 1'b1, 1'b0, 10'h020, 9'h022);
    tick();
    opL(1'b0, 1'b1, 1'b1, 10'h020, 9'h000);
    opR(1'b0, 1'b1, 1'b1, 10'h020, 9'h000);
    tick();
    chk("R10 left wins L", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h111});
    chk("R10 left wins R", {6'd0, doutValidR, doutR}, {6'd0, 1'b1, 9'h111});

    // R11: read on the same edge as the other port's write sees new word
    opL(1'b0, 1'b1, 1'b1, 10'h020, 9'h000);
    opR(1'b0, 1'b1, 1'b0, 10'h020, 9'h0C3);
    tick();
    chk("R11 new word", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h0C3});
    idleL(); idleR(); tick();

    // R5: reset beats a strobe; address goes to 0
    opR(1'b0, 1'b1, 1'b0, 10'h000, 9'h05A);
    tick();
    idleR();
    opL(1'b0, 1'b1, 1'b1, 10'h010, 9'h000);
    cntRstNL = 1'b0;
    tick();
    chk("R5 reset clears valid", {15'd0, doutValidL}, 16'd0);
    opL(1'b1, 1'b1, 1'b1, 10'h3FF, 9'h000);
    tick();
    chk("R5 reset beats strobe", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h05A});

    // R6: counting past the top address wraps to 0
    opL(1'b0, 1'b1, 1'b0, TOP, 9'h0AA);
    tick();
    opL(1'b0, 1'b1, 1'b1, TOP, 9'h000);
    tick();
    chk("R6 top word", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h0AA});
    opL(1'b1, 1'b0, 1'b1, 10'h000, 9'h000);
    tick();
    chk("R6 wrap to zero", {6'd0, doutValidL, doutL}, {6'd0, 1'b1, 9'h05A});
    idleL(); tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule